// File: doc/BRIEF.md
# Set-Associative Data Cache with Scratch-RAM Ways

This block is a data cache for a single load/store port. Each access chooses its write policy with a page-attribute input. A write-back store only marks the line dirty. A write-through store also sends the word straight to memory. Misses fetch whole 8-word lines over a memory port. A dirty victim line is always written out in full before its replacement is fetched.

A configuration input turns the lowest-numbered ways into directly addressed scratch RAM. That RAM appears in a fixed address window. An access whose way field falls inside the reconfigured ways always hits, with no tag compare, and never reaches memory. Those ways also take no part in cache lookup or replacement.

A clean-and-invalidate command walks every line, writes back each dirty one and then drops all valid bits. The geometry is set by parameters. The defaults are 32 ways by 8 sets of 32-byte lines. With 32 sets the cache reaches 32 KB.

Top module: `dcache_ramsplit`

## Requirements
- R1: After reset the block is idle: `cpu_busy`, `cpu_done`, `flush_done` and `mem_req` are all low.
- R2: A load returns the most recently stored value of its word. A load miss fetches the line as 8 single-word read beats at the line's word addresses, starting at the line base (address bits 4:0 zero). A load hit causes no memory traffic. Each memory beat holds its request and address until `mem_ack` is high.
- R3: A store with `cpu_wt`=0 that hits updates only the cached line. It produces no memory write.
- R4: A store with `cpu_wt`=1 produces exactly one memory write with `mem_burst`=0 and the store's address and data. If the line is present, the cached copy is also updated, so a following load hits with the new value.
- R5: A store miss with `cpu_wt`=1 allocates no line. A following load of that word misses and fetches 8 beats.
- R6: A store miss with `cpu_wt`=0 fetches the line with 8 read beats and merges the store into the cached copy. Memory is left unchanged.
- R7: When a miss picks a dirty victim, the victim's 8 words are written as one `mem_burst`=1 write sequence, and this finishes before the first read beat of the fill.
- R8: An address whose bits 31:13 match the window base (0x1000_0000) and whose way field (bits 12:8; set bits 7:5, word bits 4:2) is below the RAM way count is served from that way with no memory traffic.
- R9: RAM ways are never picked as victims and are never matched by a cache lookup. Their contents survive any amount of cache traffic.
- R10: Pulsing `flush_req` writes every dirty cache line to memory, then invalidates all lines, then pulses `flush_done`. Afterwards memory holds every stored value, and loads miss.
- R11: A `cfg_ram_ways` value of NWAYS or more is treated as NWAYS-1, so one cache way always remains.
- R12: When `flush_req` and `cpu_req` are both high in an idle cycle, the flush is taken and the load/store request is dropped: it produces no `cpu_done` and no effect on memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ram_ways | input | clog2(NWAYS+1) | Number of low ways used as scratch RAM; change only while idle after a flush |
| cpu_req | input | 1 | One-cycle request pulse, taken while `cpu_busy` is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_wt | input | 1 | Store policy: 1 = write-through, 0 = write-back |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Store data |
| cpu_busy | output | 1 | An operation or flush is in progress |
| cpu_done | output | 1 | One-cycle pulse ending a load/store |
| cpu_rdata | output | 32 | Load data, valid with `cpu_done` |
| flush_req | input | 1 | One-cycle clean-and-invalidate pulse |
| flush_done | output | 1 | One-cycle pulse ending a flush |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_burst | output | 1 | Beat belongs to an 8-word line transfer |
| mem_addr | output | 32 | Word address of the beat |
| mem_wdata | output | 32 | Write data of the beat |
| mem_ack | input | 1 | Beat accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
A flush command and a load/store request can both arrive in the same idle cycle, and only one of them may start. The bench provokes this after leaving a dirty line in the cache. It raises both pulses on one edge, with the store carrying a new value for that dirty word. It then judges the outcome at the ports. It expects a `flush_done` with no `cpu_done`, memory holding the older write-back value rather than the dropped store's data, and a later load that misses and returns the older value.

// File: rtl/dcache_ramsplit.sv
module dcache_ramsplit #(
  parameter int NWAYS = 32,
  parameter int NSETS = 8,
  parameter logic [31:0] RAM_BASE = 32'h1000_0000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(NWAYS+1)-1:0] cfg_ram_ways,
  input  logic                       cpu_req,
  input  logic                       cpu_we,
  input  logic                       cpu_wt,
  input  logic [31:0]                cpu_addr,
  input  logic [31:0]                cpu_wdata,
  output logic                       cpu_busy,
  output logic                       cpu_done,
  output logic [31:0]                cpu_rdata,
  input  logic                       flush_req,
  output logic                       flush_done,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic                       mem_burst,
  output logic [31:0]                mem_addr,
  output logic [31:0]                mem_wdata,
  input  logic                       mem_ack,
  input  logic [31:0]                mem_rdata
);
  localparam int WAY_W  = $clog2(NWAYS);
  localparam int SET_W  = $clog2(NSETS);
  localparam int TAG_W  = 32 - SET_W - 5;
  localparam int LINE_W = WAY_W + SET_W;
  localparam int NLINES = NWAYS * NSETS;
  localparam int WIN_W  = LINE_W + 5;
  localparam int CFG_W  = $clog2(NWAYS+1);

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_WT, S_WB, S_FILL, S_SCAN} st_t;
  st_t st;

  logic [31:0] a_q, wd_q, rd_q;
  logic we_q, wt_q, fl_q, done_q, fdone_q;
  logic [LINE_W-1:0] ln_q, scan_q;
  logic [2:0] beat_q;
  logic [WAY_W-1:0] rr_q;
  logic [NLINES-1:0] vld_q, dty_q;
  logic [TAG_W-1:0] tag_q [NLINES];
  logic [31:0] dat_q [NLINES*8];

  logic [WAY_W-1:0] nram, way_f, hway, vway;
  logic [SET_W-1:0] set_a;
  logic [TAG_W-1:0] tag_a;
  logic [2:0] word_a;
  logic [LINE_W-1:0] ram_line, hline, vline;
  logic in_ram, hit, scan_wb;

  assign nram   = (cfg_ram_ways >= CFG_W'(NWAYS)) ? WAY_W'(NWAYS-1) : cfg_ram_ways[WAY_W-1:0];
  assign set_a  = a_q[SET_W+4:5];
  assign tag_a  = a_q[31:SET_W+5];
  assign word_a = a_q[4:2];
  assign way_f  = a_q[WIN_W-1:SET_W+5];
  assign in_ram = (a_q[31:WIN_W] == RAM_BASE[31:WIN_W]) && (way_f < nram);
  assign ram_line = {set_a, way_f};

  always_comb begin
    hit  = 1'b0;
    hway = '0;
    for (int w = 0; w < NWAYS; w++)
      if (WAY_W'(w) >= nram && vld_q[{set_a, WAY_W'(w)}] && tag_q[{set_a, WAY_W'(w)}] == tag_a) begin
        hit  = 1'b1;
        hway = WAY_W'(w);
      end
  end
  assign hline = {set_a, hway};
  assign vway  = (rr_q < nram) ? nram : rr_q;
  assign vline = {set_a, vway};
  assign scan_wb = (scan_q[WAY_W-1:0] >= nram) && vld_q[scan_q] && dty_q[scan_q];

  logic dwe, twe;
  logic [LINE_W+2:0] dwa;
  logic [31:0] dwd;
  always_comb begin
    dwe = 1'b0;
    dwa = {ln_q, beat_q};
    dwd = mem_rdata;
    if (st == S_LOOK && we_q && in_ram) begin
      dwe = 1'b1; dwa = {ram_line, word_a}; dwd = wd_q;
    end else if (st == S_LOOK && we_q && hit) begin
      dwe = 1'b1; dwa = {hline, word_a}; dwd = wd_q;
    end else if (st == S_FILL && mem_ack) begin
      dwe = 1'b1;
    end
  end
  assign twe = (st == S_FILL) && mem_ack && (beat_q == 3'd7);

  always_ff @(posedge clk) begin
    if (dwe) dat_q[dwa] <= dwd;
    if (twe) tag_q[ln_q] <= tag_a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      a_q <= '0; wd_q <= '0; rd_q <= '0;
      we_q <= 1'b0; wt_q <= 1'b0; fl_q <= 1'b0;
      done_q <= 1'b0; fdone_q <= 1'b0;
      ln_q <= '0; scan_q <= '0; beat_q <= '0; rr_q <= '0;
      vld_q <= '0; dty_q <= '0;
    end else begin
      done_q  <= 1'b0;
      fdone_q <= 1'b0;
      case (st)
        S_IDLE:
          if (flush_req) begin
            scan_q <= '0;
            st <= S_SCAN;
          end else if (cpu_req) begin
            a_q <= cpu_addr; wd_q <= cpu_wdata;
            we_q <= cpu_we; wt_q <= cpu_wt;
            st <= S_LOOK;
          end
        S_LOOK: begin
          beat_q <= '0;
          if (in_ram) begin
            if (!we_q) rd_q <= dat_q[{ram_line, word_a}];
            done_q <= 1'b1;
            st <= S_IDLE;
          end else if (hit) begin
            if (!we_q) begin
              rd_q <= dat_q[{hline, word_a}];
              done_q <= 1'b1;
              st <= S_IDLE;
            end else if (wt_q) begin
              st <= S_WT;
            end else begin
              dty_q[hline] <= 1'b1;
              done_q <= 1'b1;
              st <= S_IDLE;
            end
          end else if (we_q && wt_q) begin
            st <= S_WT;
          end else begin
            ln_q <= vline;
            fl_q <= 1'b0;
            rr_q <= (vway == WAY_W'(NWAYS-1)) ? nram : vway + WAY_W'(1);
            st <= (vld_q[vline] && dty_q[vline]) ? S_WB : S_FILL;
          end
        end
        S_WT:
          if (mem_ack) begin
            done_q <= 1'b1;
            st <= S_IDLE;
          end
        S_WB:
          if (mem_ack) begin
            beat_q <= beat_q + 3'd1;
            if (beat_q == 3'd7) begin
              dty_q[ln_q] <= 1'b0;
              vld_q[ln_q] <= 1'b0;
              st <= fl_q ? S_SCAN : S_FILL;
            end
          end
        S_FILL:
          if (mem_ack) begin
            beat_q <= beat_q + 3'd1;
            if (beat_q == 3'd7) begin
              vld_q[ln_q] <= 1'b1;
              dty_q[ln_q] <= 1'b0;
              st <= S_LOOK;
            end
          end
        S_SCAN:
          if (scan_wb) begin
            ln_q <= scan_q;
            fl_q <= 1'b1;
            beat_q <= '0;
            st <= S_WB;
          end else if (scan_q == LINE_W'(NLINES-1)) begin
            vld_q <= '0;
            fdone_q <= 1'b1;
            st <= S_IDLE;
          end else begin
            scan_q <= scan_q + LINE_W'(1);
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cpu_busy   = (st != S_IDLE);
  assign cpu_done   = done_q;
  assign cpu_rdata  = rd_q;
  assign flush_done = fdone_q;
  assign mem_req    = (st == S_WT) || (st == S_WB) || (st == S_FILL);
  assign mem_we     = (st == S_WT) || (st == S_WB);
  assign mem_burst  = (st == S_WB) || (st == S_FILL);
  assign mem_addr   = (st == S_WB)   ? {tag_q[ln_q], ln_q[LINE_W-1:WAY_W], beat_q, 2'b00} :
                      (st == S_FILL) ? {a_q[31:5], beat_q, 2'b00} : {a_q[31:2], 2'b00};
  assign mem_wdata  = (st == S_WB) ? dat_q[{ln_q, beat_q}] : wd_q;

  assert_beat_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  assert_fill_after_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FILL) |-> !dty_q[ln_q]);
  assert_ram_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOOK && in_ram) |=> !mem_req);
  assert_victim_cacheable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FILL) |-> (ln_q[WAY_W-1:0] >= nram));
  assert_flush_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && cpu_req && !cpu_busy) |=> (st == S_SCAN));
endmodule

// File: tb/dcache_ramsplit_tb.sv
module dcache_ramsplit_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [5:0] cfg_ram_ways = '0;
  logic cpu_req = 0, cpu_we = 0, cpu_wt = 0, flush_req = 0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic cpu_busy, cpu_done, flush_done, mem_req, mem_we, mem_burst;
  logic [31:0] cpu_rdata, mem_addr, mem_wdata;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  dcache_ramsplit dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_ram_ways(cfg_ram_ways),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_wt(cpu_wt), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .flush_req(flush_req), .flush_done(flush_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_burst(mem_burst), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  int checks = 0, errors = 0;
  logic [31:0] mm [4096];
  logic [31:0] sh [4096];
  logic [31:0] rams [2048];
  bit ram_w [2048];
  int rdb, wrb, sgl, evicts;
  bit rd_seen, order_bad;
  logic [31:0] sgl_a, sgl_d, first_rd, r;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (rst_n && mem_req && $urandom_range(3) != 0) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        mm[mem_addr[13:2]] = mem_wdata;
        if (mem_burst) begin
          wrb++;
          if (rd_seen) order_bad = 1;
        end else begin
          sgl++; sgl_a = mem_addr; sgl_d = mem_wdata;
        end
      end else begin
        if (rdb == 0) first_rd = mem_addr;
        mem_rdata = mm[mem_addr[13:2]];
        rdb++;
        rd_seen = 1;
      end
    end
  end

  function automatic logic [31:0] cadr(input int tg, input int st, input int w);
    return {18'b0, tg[5:0], st[2:0], w[2:0], 2'b00};
  endfunction
  function automatic logic [31:0] radr(input int wy, input int st, input int w);
    return 32'h1000_0000 | {19'b0, wy[4:0], st[2:0], w[2:0], 2'b00};
  endfunction

  task automatic clr();
    rdb = 0; wrb = 0; sgl = 0; rd_seen = 0; order_bad = 0;
  endtask

  task automatic op(input bit we, input bit wt, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    while (cpu_busy) @(negedge clk);
    clr();
    cpu_req = 1; cpu_we = we; cpu_wt = wt; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 0;
    while (!cpu_done) @(negedge clk);
    r = cpu_rdata;
  endtask

  task automatic flush();
    @(negedge clk);
    while (cpu_busy) @(negedge clk);
    clr();
    flush_req = 1;
    @(negedge clk);
    flush_req = 0;
    while (!flush_done) @(negedge clk);
  endtask

  task automatic mem_match(input string req);
    int bad = 0;
    for (int i = 0; i < 4096; i++) if (mm[i] !== sh[i]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic rnd_ops(input int n);
    for (int k = 0; k < n; k++) begin
      logic [31:0] a, d;
      bit we, wt;
      a = cadr($urandom_range(63), $urandom_range(1), $urandom_range(7));
      we = $urandom_range(1); wt = $urandom_range(1); d = $urandom;
      op(we, wt, a, d);
      if (!we) chk(r == sh[a[13:2]], "R2 load value", r, sh[a[13:2]]);
      else sh[a[13:2]] = d;
      chk(!order_bad, "R7 writeback before fill", order_bad, 0);
      chk(wrb == 0 || wrb == 8, "R7 writeback length", wrb, 8);
      if (wrb == 8) evicts++;
      if (we && wt) chk(sgl == 1 && sgl_a == a && sgl_d == d, "R4 single write", sgl_d, d);
      else chk(sgl == 0, "R3 no single write", sgl, 0);
    end
  endtask

  task automatic ram_ops(input int n, input int lo, input int hi);
    for (int k = 0; k < n; k++) begin
      logic [31:0] a, d;
      a = radr($urandom_range(hi, lo), $urandom_range(7), $urandom_range(7));
      d = $urandom;
      op(1, $urandom_range(1), a, d);
      rams[a[12:2]] = d; ram_w[a[12:2]] = 1;
      chk(rdb + wrb + sgl == 0, "R8 ram store quiet", rdb + wrb + sgl, 0);
      op(0, 0, a, 0);
      chk(r == d && rdb + wrb + sgl == 0, "R8 ram load", r, d);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [31:0] a, b, c, x, old;
    bit saw;
    process::self().srandom(32'h5eed_0042);
    for (int i = 0; i < 4096; i++) begin mm[i] = $urandom; sh[i] = mm[i]; end
    evicts = 0;
    repeat (3) @(negedge clk);
    chk(!cpu_busy && !cpu_done && !flush_done && !mem_req, "R1 reset idle",
        {cpu_busy, cpu_done, flush_done, mem_req}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!cpu_busy && !mem_req, "R1 idle after release", {cpu_busy, mem_req}, 0);

    a = cadr(1, 0, 3); b = cadr(2, 0, 5); c = cadr(3, 0, 6);
    op(0, 0, a, 0);
    chk(r == sh[a[13:2]], "R2 miss value", r, sh[a[13:2]]);
    chk(rdb == 8 && wrb == 0, "R2 fill beats", rdb, 8);
    chk(first_rd == {a[31:5], 5'b0}, "R2 fill base", first_rd, {a[31:5], 5'b0});
    op(0, 0, a, 0);
    chk(rdb + wrb + sgl == 0 && r == sh[a[13:2]], "R2 hit quiet", rdb + wrb + sgl, 0);
    op(1, 0, a, 32'hA5A5_0001); sh[a[13:2]] = 32'hA5A5_0001;
    chk(rdb + wrb + sgl == 0, "R3 wb hit quiet", rdb + wrb + sgl, 0);
    chk(mm[a[13:2]] != 32'hA5A5_0001, "R3 memory untouched", mm[a[13:2]], 0);
    op(1, 1, a, 32'hC0DE_0002); sh[a[13:2]] = 32'hC0DE_0002;
    chk(sgl == 1 && sgl_a == a && sgl_d == 32'hC0DE_0002 && wrb == 0, "R4 wt hit write", sgl_d, 32'hC0DE_0002);
    op(0, 0, a, 0);
    chk(r == 32'hC0DE_0002 && rdb == 0, "R4 line updated", r, 32'hC0DE_0002);
    op(1, 1, b, 32'h0BAD_0003); sh[b[13:2]] = 32'h0BAD_0003;
    chk(sgl == 1 && rdb == 0 && mm[b[13:2]] == 32'h0BAD_0003, "R4 wt miss write", mm[b[13:2]], 32'h0BAD_0003);
    op(0, 0, b, 0);
    chk(rdb == 8 && r == 32'h0BAD_0003, "R5 no allocate", rdb, 8);
    old = mm[c[13:2]];
    op(1, 0, c, 32'h7777_0004); sh[c[13:2]] = 32'h7777_0004;
    chk(rdb == 8 && sgl == 0 && mm[c[13:2]] == old, "R6 wb miss fill", mm[c[13:2]], old);
    op(0, 0, c, 0);
    chk(r == 32'h7777_0004 && rdb == 0, "R6 merged", r, 32'h7777_0004);

    rnd_ops(500);
    chk(evicts > 0, "R7 evictions seen", evicts, 1);

    x = cadr(9, 1, 2);
    op(1, 0, x, 32'h1111_2222); sh[x[13:2]] = 32'h1111_2222;
    @(negedge clk);
    clr();
    saw = 0;
    flush_req = 1; cpu_req = 1; cpu_we = 1; cpu_wt = 1; cpu_addr = x; cpu_wdata = 32'h9999_8888;
    @(negedge clk);
    flush_req = 0; cpu_req = 0;
    while (!flush_done) begin
      if (cpu_done) saw = 1;
      @(negedge clk);
    end
    repeat (3) begin @(negedge clk); if (cpu_done) saw = 1; end
    chk(!saw, "R12 request dropped", saw, 0);
    chk(mm[x[13:2]] == 32'h1111_2222, "R12 flush wins", mm[x[13:2]], 32'h1111_2222);
    mem_match("R10 memory clean after flush");
    op(0, 0, x, 0);
    chk(rdb == 8 && r == 32'h1111_2222, "R10 invalidated", rdb, 8);

    flush();
    cfg_ram_ways = 6'd4;
    ram_ops(40, 0, 3);
    rnd_ops(300);
    begin
      int bad = 0;
      for (int i = 0; i < 2048; i++) if (ram_w[i]) begin
        op(0, 0, 32'h1000_0000 | {19'b0, i[10:0], 2'b00}, 0);
        if (r != rams[i] || rdb + wrb + sgl != 0) bad++;
      end
      chk(bad == 0, "R9 ram survives traffic", bad, 0);
    end

    flush();
    mem_match("R10 memory clean second flush");
    cfg_ram_ways = 6'd40;
    ram_ops(10, 8, 30);
    a = cadr(5, 1, 1); b = cadr(6, 1, 4);
    op(1, 0, a, 32'hDEAD_0005); sh[a[13:2]] = 32'hDEAD_0005;
    op(0, 0, b, 0);
    chk(wrb == 8 && rdb == 8 && !order_bad, "R11 single cache way evicts", wrb, 8);
    chk(mm[a[13:2]] == 32'hDEAD_0005, "R7 victim data written", mm[a[13:2]], 32'hDEAD_0005);
    chk(r == sh[b[13:2]], "R2 load after eviction", r, sh[b[13:2]]);
    rnd_ops(100);
    flush();
    mem_match("R10 memory clean final");
    summary();
  end
endmodule